// File: doc/BRIEF.md
# Sectioned ROM Checksum Verifier

This block holds a 128-byte information image in an internal byte store that is filled through a valid/ready load port. A one-cycle start pulse makes it walk the image from address 00h to 7Fh, one byte per clock. The image is split into eight consecutive sections. Each section ends in a one-byte checksum that must equal the two's complement of the 8-bit sum of the data bytes before it. The walk sets one pass bit per section, and at the end it raises an overall pass flag and a one-cycle done pulse.

The block has a generate mode, chosen when the walk starts. In this mode it offers the checksum it computed for each section on a valid/ready output stream as the walk reaches the section's checksum byte. The load port applies back-pressure by holding its ready low for the whole walk. The generate stream's consumer can apply back-pressure by holding its ready low. The walk then freezes on that checksum byte, and the offered byte and section number stay unchanged until the transfer completes. Control and status pins are plain levels and pulses.

Top module: `romck_verifier`

## Requirements
- R1: The checksum of a section is the two's complement of the 8-bit sum of its data bytes. The data bytes AAh, 44h and 5Ch give checksum B6h.
- R2: The checksum bytes sit at 0Dh, 15h, 24h, 31h, 37h, 6Fh, 73h and 7Fh. A section's data runs from one past the previous checksum address (from 00h for the first section) up to, but not including, its own checksum address.
- R3: Bit n of `sect_pass` is set when section n (0 = first, 7 = last) matches its stored byte. `all_pass` is high after a completed walk only if all eight bits are set.
- R4: Comparing the negated sum with the stored byte gives the same verdict as testing that the sum of the data bytes plus the stored byte is 00h, for every stored value 00h to FFh.
- R5: With no back-pressure, `done` is high for exactly one cycle. That cycle begins 128 clock edges after the edge that accepted start. The flags then hold until the next accepted start.
- R6: A start pulse while `busy` is high is ignored. The walk keeps its timing and produces a single done pulse.
- R7: A synchronous reset, taken at any time, clears `busy`, `done`, `sect_pass` and `all_pass`. After it, no done pulse appears until a new start.
- R8: `ld_ready` is high exactly when the block is idle. A byte is written when `ld_valid` and `ld_ready` are both high. An offer made while busy leaves the image unchanged. A write accepted in the same cycle as start is included in that walk.
- R9: In generate mode, `gen_valid` rises at each section's checksum address, in section order, with `gen_sect` set to the section number and `gen_byte` set to the computed checksum. While `gen_ready` is low, both stay stable and the walk stalls.
- R10: When generate mode was low at start, `gen_valid` stays low for the whole walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, honoured only when idle |
| gen_mode | input | 1 | Sampled at start; enables the generate stream |
| ld_valid | input | 1 | Load byte offered |
| ld_ready | output | 1 | Load byte accepted (idle) |
| ld_addr | input | 7 | Load address |
| ld_data | input | 8 | Load data |
| gen_valid | output | 1 | Computed checksum offered |
| gen_ready | input | 1 | Consumer accepts the checksum |
| gen_sect | output | 3 | Section of the offered checksum |
| gen_byte | output | 8 | Computed checksum |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| sect_pass | output | 8 | Per-section pass flags |
| all_pass | output | 1 | All sections passed on the last completed walk |

## Verification
Two pairs of functions can meet in the same cycle. The first is a load write and the start that begins a walk. The bench offers a corrupted checksum byte in the very cycle start is raised and expects that section to fail, which shows the write was taken into the walk. The second is a generate-stream stall and the compare at a checksum byte. The bench drives `gen_ready` low in two of every three cycles, then checks that the offered byte and section stay stable, that each checksum is delivered once and in order, and that the flags still match the expected values computed in the bench.

// File: rtl/romck_pkg.sv
package romck_pkg;
  localparam int SECT_N = 8;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  // Address of the checksum byte closing section s; behaviour depends on it.
  function automatic logic [ADDR_W-1:0] sect_end(input int unsigned s);
    case (s)
      0:       return 7'h0D;
      1:       return 7'h15;
      2:       return 7'h24;
      3:       return 7'h31;
      4:       return 7'h37;
      5:       return 7'h6F;
      6:       return 7'h73;
      default: return 7'h7F;
    endcase
  endfunction
endpackage

// File: rtl/romck_store.sv
module romck_store #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/romck_accum.sv
module romck_accum #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          is_chk,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] ck_byte,
  output logic          match
);
  logic [DW-1:0] acc;
  logic [DW-1:0] total;

  assign ck_byte = ~acc + 1'b1;
  assign match   = (ck_byte == din);
  assign total   = acc + din;

  always_ff @(posedge clk) begin
    if (rst || clr)  acc <= '0;
    else if (en)     acc <= is_chk ? '0 : total;
  end

  // R4: negate-and-compare agrees with sum-to-zero
  a_r4_methods_agree: assert property (@(posedge clk) disable iff (rst)
    (en && is_chk) |-> (match == (total == '0)));
endmodule

// File: rtl/romck_verifier.sv
module romck_verifier
  import romck_pkg::*;
#(
  parameter int NSECT = SECT_N,
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             gen_mode,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [AW-1:0]    ld_addr,
  input  logic [DW-1:0]    ld_data,
  output logic             gen_valid,
  input  logic             gen_ready,
  output logic [$clog2(NSECT)-1:0] gen_sect,
  output logic [DW-1:0]    gen_byte,
  output logic             busy,
  output logic             done,
  output logic [NSECT-1:0] sect_pass,
  output logic             all_pass
);
  localparam int SW = $clog2(NSECT);
  localparam logic [AW-1:0] LAST = AW'(2 ** AW - 1);

  typedef enum logic {ST_IDLE, ST_RUN} st_t;
  st_t st;

  logic [AW-1:0]    addr;
  logic [SW-1:0]    sect;
  logic [NSECT-1:0] pass_r;
  logic             done_r, res_v, gen_q;
  logic [DW-1:0]    rd_byte, ck_byte;
  logic             match, at_chk, stall, step, go;

  assign go       = (st == ST_IDLE) && start;
  assign ld_ready = (st == ST_IDLE);
  assign at_chk   = (st == ST_RUN) && (addr == sect_end(int'(sect)));
  assign stall    = gen_q && at_chk && !gen_ready;
  assign step     = (st == ST_RUN) && !stall;

  romck_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .we(ld_valid && ld_ready), .waddr(ld_addr), .wdata(ld_data),
    .raddr(addr), .rdata(rd_byte)
  );

  romck_accum #(.DW(DW)) u_accum (
    .clk(clk), .rst(rst), .clr(go), .en(step), .is_chk(at_chk),
    .din(rd_byte), .ck_byte(ck_byte), .match(match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; addr <= '0; sect <= '0; pass_r <= '0;
      done_r <= 1'b0; res_v <= 1'b0; gen_q <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st <= ST_RUN; addr <= '0; sect <= '0; pass_r <= '0;
          res_v <= 1'b0; gen_q <= gen_mode;
        end
        ST_RUN: if (step) begin
          addr <= addr + 1'b1;
          if (at_chk) begin
            pass_r[sect] <= match;
            sect <= SW'(sect + 1'b1);
          end
          if (addr == LAST) begin
            st <= ST_IDLE; done_r <= 1'b1; res_v <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st == ST_RUN);
  assign done      = done_r;
  assign sect_pass = pass_r;
  assign all_pass  = res_v && (&pass_r);
  assign gen_valid = gen_q && at_chk;
  assign gen_sect  = sect;
  assign gen_byte  = ck_byte;

  // R5: done lasts one cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: offered checksum held while stalled
  a_r9_gen_hold: assert property (@(posedge clk) disable iff (rst)
    (gen_valid && !gen_ready) |=> (gen_valid && $stable(gen_byte) && $stable(gen_sect)));
  // R3: overall flag tracks section flags at completion
  a_r3_all_on_done: assert property (@(posedge clk) disable iff (rst)
    done |-> (all_pass == (&sect_pass)));
  // R7: reset clears status
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (!busy && !done && sect_pass == '0 && !all_pass));
  // R10: generate stream only during a walk
  a_r10_gen_in_walk: assert property (@(posedge clk) disable iff (rst)
    gen_valid |-> busy);
endmodule

// File: tb/tb_romck_verifier.sv
`timescale 1ns/1ps
module tb_romck_verifier;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0, gen_mode = 1'b0;
  logic ld_valid = 1'b0, gen_ready = 1'b1;
  logic [6:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic ld_ready, gen_valid, busy, done, all_pass;
  logic [2:0] gen_sect;
  logic [7:0] gen_byte, sect_pass;

  always #2.5 clk = ~clk;

  romck_verifier dut (
    .clk(clk), .rst(rst), .start(start), .gen_mode(gen_mode),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data),
    .gen_valid(gen_valid), .gen_ready(gen_ready), .gen_sect(gen_sect), .gen_byte(gen_byte),
    .busy(busy), .done(done), .sect_pass(sect_pass), .all_pass(all_pass)
  );

  int nchk = 0, nfail = 0;
  logic [7:0] img [128];
  int ends [8] = '{'h0D, 'h15, 'h24, 'h31, 'h37, 'h6F, 'h73, 'h7F};
  int gcnt, gviol, gseen;
  logic [2:0] gs [8];
  logic [7:0] gb [8];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sfirst(input int s);
    return (s == 0) ? 0 : ends[s-1] + 1;
  endfunction

  function automatic logic [7:0] dsum(input int s);
    logic [7:0] a = 8'h00;
    for (int i = sfirst(s); i < ends[s]; i++) a = a + img[i];
    return a;
  endfunction

  function automatic logic [7:0] exp_ck(input int s);
    return 8'h00 - dsum(s);
  endfunction

  function automatic logic [7:0] exp_flags();
    logic [7:0] f;
    for (int s = 0; s < 8; s++) f[s] = (exp_ck(s) == img[ends[s]]);
    return f;
  endfunction

  task automatic build(input int seed);
    for (int i = 0; i < 128; i++) img[i] = 8'((i * 37 + seed * 11 + 5) ^ (i >> 2));
    img['h70] = 8'hAA; img['h71] = 8'h44; img['h72] = 8'h5C;
    for (int s = 0; s < 8; s++) img[ends[s]] = exp_ck(s);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    ld_valid = 1'b1; ld_addr = 7'(a); ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic load_all();
    for (int i = 0; i < 128; i++) wr(i, img[i]);
  endtask

  // Called at a negedge. Returns the cycle of the first done pulse (0 if none).
  task automatic run(input bit gm, input int rdy_pat, input int start_at,
                     input int wr_at, input int rst_at, input int co_addr,
                     output int dcyc, output int ndone);
    int cyc;
    bit pv;
    logic [7:0] pb;
    logic [2:0] ps;
    gcnt = 0; gviol = 0; gseen = 0; dcyc = 0; ndone = 0; pv = 0; pb = '0; ps = '0;
    start = 1'b1; gen_mode = gm; gen_ready = (rdy_pat == 0);
    if (co_addr >= 0) begin
      ld_valid = 1'b1; ld_addr = 7'(co_addr); ld_data = img[co_addr];
    end
    @(negedge clk);
    start = 1'b0; ld_valid = 1'b0;
    cyc = 0;
    while (cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (pv && !(gen_valid && gen_byte == pb && gen_sect == ps)) gviol++;
      gen_ready = (rdy_pat == 0) ? 1'b1 : (cyc % 3 == 0);
      if (gen_valid) gseen++;
      if (gen_valid && gen_ready && gcnt < 8) begin
        gs[gcnt] = gen_sect; gb[gcnt] = gen_byte; gcnt++;
      end
      pv = gen_valid && !gen_ready; pb = gen_byte; ps = gen_sect;
      if (done) begin ndone++; if (ndone == 1) dcyc = cyc; end
      start = (cyc == start_at);
      if (wr_at >= 0 && cyc >= wr_at && cyc < wr_at + 4) begin
        ld_valid = 1'b1; ld_addr = 7'h0D; ld_data = ~img['h0D];
        chk(ld_ready == 1'b0, "R8 ld_ready low while busy", ld_ready, 0);
      end else ld_valid = 1'b0;
      if (rst_at >= 0 && cyc == rst_at) rst = 1'b1;
      if (rst_at >= 0 && cyc == rst_at + 1) begin
        rst = 1'b0;
        chk(!busy && !done && sect_pass == 8'h00 && !all_pass, "R7 reset mid-walk clears",
            {busy, done, all_pass, sect_pass}, 0);
      end
      if (rst_at < 0 && ndone > 0 && cyc >= dcyc + 12) break;
      if (rst_at >= 0 && cyc >= 300) break;
    end
    start = 1'b0; ld_valid = 1'b0; gen_ready = 1'b1;
  endtask

  initial begin
    #(5.0 * 200000);
    nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int dc, nd;
    logic [7:0] ef, v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    chk(!busy && !done && sect_pass == 0 && !all_pass && !gen_valid, "R7 reset state",
        {busy, done, gen_valid, sect_pass}, 0);
    chk(ld_ready == 1'b1, "R8 ld_ready when idle", ld_ready, 1);

    // Clean image: all pass, timing, no stream
    build(1); load_all();
    run(0, 0, -1, -1, -1, -1, dc, nd);
    chk(dc == 128, "R5 done timing", dc, 128);
    chk(nd == 1, "R5 single done", nd, 1);
    chk(sect_pass == 8'hFF, "R3 clean flags", sect_pass, 8'hFF);
    chk(all_pass == 1'b1, "R3 all_pass clean", all_pass, 1);
    chk(gseen == 0, "R10 no stream without gen mode", gseen, 0);
    repeat (5) @(negedge clk);
    chk(sect_pass == 8'hFF && all_pass && !done, "R5 flags hold", sect_pass, 8'hFF);

    // Boundaries: corrupt stored byte, first and last data byte of each section
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 3; k++) begin
        int a;
        a = (k == 0) ? ends[s] : (k == 1) ? sfirst(s) : ends[s] - 1;
        img[a] = img[a] ^ 8'h01; wr(a, img[a]);
        ef = exp_flags();
        run(0, 0, -1, -1, -1, -1, dc, nd);
        chk(sect_pass == ef && ef == ~(8'h01 << s), "R2 section boundary", sect_pass, ef);
        chk(all_pass == 1'b0, "R3 all_pass low on mismatch", all_pass, 0);
        img[a] = img[a] ^ 8'h01; wr(a, img[a]);
      end
    end

    // Sweep stored checksum of section 0 over every value
    for (int x = 0; x < 256; x++) begin
      bit m1, m2;
      v = 8'(x);
      wr('h0D, v);
      m1 = (v == exp_ck(0));
      m2 = (8'(dsum(0) + v) == 8'h00);
      run(0, 0, -1, -1, -1, -1, dc, nd);
      chk(m1 == m2 && sect_pass[0] == m1, "R4 sweep section 0", sect_pass[0], m1);
    end
    wr('h0D, img['h0D]);

    // Generate mode under back-pressure
    run(1, 1, -1, -1, -1, -1, dc, nd);
    chk(gcnt == 8, "R9 eight checksums delivered", gcnt, 8);
    for (int s = 0; s < 8; s++)
      chk(gs[s] == 3'(s) && gb[s] == exp_ck(s), "R9 stream order/value", {gs[s], gb[s]}, {s[2:0], exp_ck(s)});
    chk(gb[6] == 8'hB6, "R1 AA 44 5C gives B6", gb[6], 8'hB6);
    chk(gviol == 0, "R9 stable while stalled", gviol, 0);
    chk(dc > 128, "R9 walk stalls", dc, 129);
    chk(sect_pass == 8'hFF && nd == 1, "R9 flags in gen mode", sect_pass, 8'hFF);

    // Start while busy
    run(0, 0, 50, -1, -1, -1, dc, nd);
    chk(dc == 128 && nd == 1, "R6 start while busy ignored", {dc, nd}, {128, 1});
    repeat (3) @(negedge clk);
    chk(!busy, "R6 no second walk", busy, 0);

    // Write offered while busy is not taken
    run(0, 0, -1, 30, -1, -1, dc, nd);
    run(0, 0, -1, -1, -1, -1, dc, nd);
    chk(sect_pass == 8'hFF, "R8 busy write dropped", sect_pass, 8'hFF);

    // Write accepted in the start cycle is included
    img['h15] = img['h15] ^ 8'h01;
    run(0, 0, -1, -1, -1, 'h15, dc, nd);
    chk(sect_pass == 8'hFD, "R8 write with start included", sect_pass, 8'hFD);
    img['h15] = img['h15] ^ 8'h01; wr('h15, img['h15]);

    // Reset mid-walk
    run(0, 0, -1, -1, 60, -1, dc, nd);
    chk(nd == 0 && !busy, "R7 no done after reset", nd, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule